// File: doc/BRIEF.md
# Sample Capture Memory Controller

This block stores sampled logic-analyzer inputs in an on-chip circular buffer and streams them back out once a capture is complete. The 32-bit sample word is split into four 8-bit channel groups. Each group can be switched on independently. The enabled groups of one sample are compacted and packed into fixed-width memory words, so a narrower capture reaches proportionally further back in time with the same memory.

A sample strobe comes from one of two places. The first is an internal divider that fires once every N+1 system clocks. The second is an externally supplied strobe that bypasses the divider. After an arm command the buffer fills continuously. When the trigger input is seen, the block stores a configured number of post-trigger samples, rounded up to a whole memory word, and then stops. That number sets how the window is split between data before and after the trigger. The stored samples are then sent oldest first over a byte-wide valid/ready output. A busy flag covers the whole capture and readback.

Top module: `cap_capture_ctrl`

## Requirements
- R1: With `ext_sel`=0 and `div_n`=N, samples are taken every N+1 system clocks, so consecutive stored samples of a ramp input differ by exactly N+1. `ext_strobe` is ignored in this mode.
- R2: With `ext_sel`=1, exactly one sample is taken in each clock cycle where `ext_strobe` is high, whatever the value of `div_n`.
- R3: Group g is `sample_in[8g+7:8g]`. Each stored sample yields one output byte per enabled group, in ascending group order. Bytes of disabled groups never appear.
- R4: With G enabled groups, the buffer holds WORDS*floor(4/G) samples, where WORDS = 2^ADDR_W. When more samples than that were taken, only the newest are read back.
- R5: Readback sends samples oldest first, wrapping around the buffer. Within a memory word the earliest sample comes first.
- R6: Let t be the number of samples taken before the trigger, counting a sample taken in the trigger's own cycle as post-trigger, and let P be `post_len`. The capture holds exactly the smallest n ≥ t+P that is a multiple of floor(4/G). Later strobes are ignored.
- R7: `busy` is high from the cycle after an accepted arm, and falls in the cycle after the last byte handshake. If nothing was stored, `busy` falls right after the capture ends. `out_valid` is high only while `busy` is high.
- R8: An arm while `busy` is high, or an arm with `grp_en`=0, has no effect.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R10: If fewer than capacity samples were stored, all n are read back starting from the first sample after the arm.
- R11: During and right after reset, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start-capture command pulse |
| grp_en | input | GRP_N | Channel group enables, latched at arm |
| post_len | input | POST_W | Post-trigger sample count, latched at arm |
| div_n | input | DIV_W | Divider setting N (strobe every N+1 clocks) |
| ext_sel | input | 1 | Select external sample strobe |
| ext_strobe | input | 1 | External sample strobe, one sample per high cycle |
| sample_in | input | GRP_N*GRP_W | Sampled channel inputs |
| trigger | input | 1 | Trigger event from the trigger logic |
| busy | output | 1 | Capture or readback in progress |
| out_data | output | GRP_W | Readback byte |
| out_valid | output | 1 | Readback byte valid |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The bench targets partial-word endings. Every group pattern is run with trigger positions that leave the packing slot in the middle of a word. A design that stops on the exact sample count rather than the word boundary would return a wrong byte count. Long pre-trigger runs force the buffer to wrap, so a wrong oldest-word pointer shows up as rotated or stale data. Runs that trigger before the buffer fills would expose a design that reads unwritten words. Coincident versus gap-cycle triggers, stray arms during capture and random output back-pressure catch off-by-one post counting, restarted captures and bytes dropped or repeated under stalls.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_CAPT, ST_READ} cap_state_e;
  typedef enum logic [1:0] {RB_IDLE, RB_FETCH, RB_LOAD, RB_SEND} rb_state_e;

  function automatic int count_ones(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += v[i] ? 1 : 0;
    return n;
  endfunction

  function automatic int slots_per_word(input int lanes, input int ng);
    return (ng == 0) ? lanes : lanes / ng;
  endfunction

  function automatic int bytes_per_word(input int lanes, input int ng);
    return slots_per_word(lanes, ng) * ((ng == 0) ? 1 : ng);
  endfunction

endpackage

// File: rtl/cap_rate_div.sv
module cap_rate_div #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_n,
  input  logic             ext_sel,
  input  logic             ext_strobe,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (cnt >= div_n) begin
      cnt    <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = ext_sel ? ext_strobe : tick_q;
endmodule

// File: rtl/cap_packer.sv
module cap_packer import cap_pkg::*; #(
  parameter int GRP_N = 4,
  parameter int GRP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic [GRP_N-1:0]       grp_en,
  input  logic                   take,
  input  logic [GRP_N*GRP_W-1:0] sample,
  output logic [GRP_N*GRP_W-1:0] wr_word,
  output logic                   wr_fire,
  output logic                   slot_zero
);
  localparam int SMP_W  = GRP_N * GRP_W;
  localparam int SLOT_W = (GRP_N > 1) ? $clog2(GRP_N) : 1;

  logic [SMP_W-1:0]  packed_smp, word_q, merged;
  logic [SLOT_W-1:0] slot;
  int                ng, spw;
  logic              last_slot;

  always_comb begin
    ng = count_ones(32'(grp_en));
    if (ng == 0) ng = 1;
    spw = slots_per_word(GRP_N, ng);
  end

  always_comb begin
    int idx;
    idx = 0;
    packed_smp = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (grp_en[g]) begin
        packed_smp[idx*GRP_W +: GRP_W] = sample[g*GRP_W +: GRP_W];
        idx++;
      end
    end
  end

  always_comb begin
    int base;
    base = int'(slot) * ng;
    merged = word_q;
    for (int b = 0; b < GRP_N; b++) begin
      if (b >= base && b < base + ng)
        merged[b*GRP_W +: GRP_W] = packed_smp[(b-base)*GRP_W +: GRP_W];
    end
  end

  assign last_slot = (int'(slot) == spw - 1);
  assign wr_fire   = take && last_slot;
  assign wr_word   = merged;
  assign slot_zero = (slot == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      slot   <= '0;
      word_q <= '0;
    end else if (take) begin
      if (last_slot) begin
        slot   <= '0;
        word_q <= '0;
      end else begin
        slot   <= slot + 1'b1;
        word_q <= merged;
      end
    end
  end
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cap_readback.sv
module cap_readback import cap_pkg::*; #(
  parameter int AW    = 10,
  parameter int GRP_N = 4,
  parameter int GRP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [AW-1:0]             start_addr,
  input  logic [AW:0]               word_cnt,
  input  logic [$clog2(GRP_N+1)-1:0] bpw,
  output logic                      rd_en,
  output logic [AW-1:0]             rd_addr,
  input  logic [GRP_N*GRP_W-1:0]    rdata,
  output logic [GRP_W-1:0]          out_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      done
);
  localparam int BPW_W = $clog2(GRP_N+1);

  rb_state_e              st;
  logic [AW-1:0]          addr_q;
  logic [AW:0]            left_q;
  logic [BPW_W-1:0]       bpw_q, idx_q;
  logic [GRP_N*GRP_W-1:0] word_q;
  logic                   last_byte, last_word;

  assign rd_en     = (st == RB_FETCH);
  assign rd_addr   = addr_q;
  assign last_byte = (idx_q == bpw_q - 1'b1);
  assign last_word = (left_q == (AW+1)'(1));
  assign done      = (st == RB_SEND) && out_ready && last_byte && last_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RB_IDLE;
      addr_q    <= '0;
      left_q    <= '0;
      bpw_q     <= '0;
      idx_q     <= '0;
      word_q    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      case (st)
        RB_IDLE: if (start) begin
          addr_q <= start_addr;
          left_q <= word_cnt;
          bpw_q  <= bpw;
          st     <= RB_FETCH;
        end
        RB_FETCH: st <= RB_LOAD;
        RB_LOAD: begin
          word_q    <= rdata;
          out_data  <= rdata[GRP_W-1:0];
          out_valid <= 1'b1;
          idx_q     <= '0;
          st        <= RB_SEND;
        end
        RB_SEND: if (out_ready) begin
          if (last_byte) begin
            out_valid <= 1'b0;
            if (last_word) st <= RB_IDLE;
            else begin
              addr_q <= addr_q + 1'b1;
              left_q <= left_q - 1'b1;
              st     <= RB_FETCH;
            end
          end else begin
            idx_q    <= idx_q + 1'b1;
            out_data <= word_q[(int'(idx_q)+1)*GRP_W +: GRP_W];
          end
        end
        default: st <= RB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_capture_ctrl.sv
module cap_capture_ctrl import cap_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DIV_W  = 24,
  parameter int POST_W = 16,
  parameter int GRP_N  = 4,
  parameter int GRP_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arm,
  input  logic [GRP_N-1:0]       grp_en,
  input  logic [POST_W-1:0]      post_len,
  input  logic [DIV_W-1:0]       div_n,
  input  logic                   ext_sel,
  input  logic                   ext_strobe,
  input  logic [GRP_N*GRP_W-1:0] sample_in,
  input  logic                   trigger,
  output logic                   busy,
  output logic [GRP_W-1:0]       out_data,
  output logic                   out_valid,
  input  logic                   out_ready
);
  localparam int SMP_W = GRP_N * GRP_W;
  localparam int WORDS = 1 << ADDR_W;
  localparam int BPW_W = $clog2(GRP_N+1);

  cap_state_e        state;
  logic [GRP_N-1:0]  en_q;
  logic [POST_W-1:0] post_q, post_cnt;
  logic [ADDR_W-1:0] wr_ptr, rd_addr, rb_base;
  logic [ADDR_W:0]   rb_cnt;
  logic [BPW_W-1:0]  rb_bpw;
  logic [SMP_W-1:0]  wr_word, rd_data;
  logic              wrapped, trig_seen, trig_now;
  logic              tick, take, arm_ok, end_now, rb_start;
  logic              wr_fire, slot_zero, rd_en, rb_done;

  cap_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_n(div_n), .ext_sel(ext_sel),
    .ext_strobe(ext_strobe), .tick(tick)
  );

  assign arm_ok   = (state == ST_IDLE) && arm && (|grp_en);
  assign trig_now = trig_seen || trigger;
  assign end_now  = (state == ST_CAPT) && trig_now && (post_cnt >= post_q) && slot_zero;
  assign take     = (state == ST_CAPT) && tick && !end_now;

  cap_packer #(.GRP_N(GRP_N), .GRP_W(GRP_W)) u_pack (
    .clk(clk), .rst(rst), .clear(arm_ok), .grp_en(en_q), .take(take),
    .sample(sample_in), .wr_word(wr_word), .wr_fire(wr_fire), .slot_zero(slot_zero)
  );

  cap_ram #(.AW(ADDR_W), .DW(SMP_W)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(wr_word),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  assign rb_base  = wrapped ? wr_ptr : '0;
  assign rb_cnt   = wrapped ? WORDS[ADDR_W:0] : {1'b0, wr_ptr};
  assign rb_bpw   = BPW_W'(bytes_per_word(GRP_N, count_ones(32'(en_q))));
  assign rb_start = end_now && (rb_cnt != '0);

  cap_readback #(.AW(ADDR_W), .GRP_N(GRP_N), .GRP_W(GRP_W)) u_rb (
    .clk(clk), .rst(rst), .start(rb_start), .start_addr(rb_base),
    .word_cnt(rb_cnt), .bpw(rb_bpw), .rd_en(rd_en), .rd_addr(rd_addr),
    .rdata(rd_data), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(rb_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      en_q      <= '0;
      post_q    <= '0;
      post_cnt  <= '0;
      wr_ptr    <= '0;
      wrapped   <= 1'b0;
      trig_seen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (arm_ok) begin
          state     <= ST_CAPT;
          en_q      <= grp_en;
          post_q    <= post_len;
          post_cnt  <= '0;
          wr_ptr    <= '0;
          wrapped   <= 1'b0;
          trig_seen <= 1'b0;
        end
        ST_CAPT: begin
          if (trigger) trig_seen <= 1'b1;
          if (take && trig_now && (post_cnt != '1)) post_cnt <= post_cnt + 1'b1;
          if (wr_fire) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_ptr == ADDR_W'(WORDS-1)) wrapped <= 1'b1;
          end
          if (end_now) begin
            if (rb_cnt == '0) state <= ST_IDLE;
            else              state <= ST_READ;
          end
        end
        ST_READ: if (rb_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/cap_capture_chk.sv
module cap_capture_chk #(
  parameter int GRP_N = 4,
  parameter int GRP_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic [GRP_N-1:0] grp_en,
  input logic             busy,
  input logic [GRP_W-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready
);
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R7

  AST_ARM_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && arm && (grp_en != '0)) |=> busy); // R7

  AST_EMPTY_ARM_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && arm && (grp_en == '0)) |=> !busy); // R8

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !out_valid)); // R11
endmodule

bind cap_capture_ctrl cap_capture_chk #(.GRP_N(GRP_N), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .grp_en(grp_en), .busy(busy),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/tb_cap_capture_ctrl.sv
module tb_cap_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 8;
  localparam int POST_W = 8;
  localparam int WORDS  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic [3:0]  grp_en = 4'hF;
  logic [7:0]  post_len = '0;
  logic [7:0]  div_n = 8'd200;
  logic        ext_sel = 1'b1;
  logic        ext_strobe = 1'b0;
  logic [31:0] sample_in = '0;
  logic        trigger = 1'b0;
  logic        busy, out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  int pcyc = 0;
  int last_hs = 0;
  int fall_cyc = 0;
  int rx_n = 0;
  logic [7:0]  rx [512];
  logic [31:0] smp [256];
  logic prev_v = 1'b0, prev_r = 1'b0, prev_busy = 1'b0;
  logic [7:0] prev_d = '0;

  cap_capture_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .POST_W(POST_W),
                     .GRP_N(4), .GRP_W(8)) dut (
    .clk(clk), .rst(rst), .arm(arm), .grp_en(grp_en), .post_len(post_len),
    .div_n(div_n), .ext_sel(ext_sel), .ext_strobe(ext_strobe),
    .sample_in(sample_in), .trigger(trigger), .busy(busy),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  // output monitor and back-pressure driver
  always @(negedge clk) begin
    if (prev_v && !prev_r && !rst)
      check(out_valid && (out_data == prev_d), "R9 hold under stall",
            int'(out_data), int'(prev_d));
    if (prev_busy && !busy) fall_cyc = pcyc;
    prev_busy = busy;
    out_ready = ($urandom % 4) != 0;
    if (out_valid && out_ready && !rst) begin
      if (rx_n < 512) rx[rx_n] = out_data;
      rx_n++;
      last_hs = pcyc;
    end
    prev_v = out_valid;
    prev_r = out_ready;
    prev_d = out_data;
  end

  task automatic wait_idle();
    for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
  endtask

  task automatic do_arm(input logic [3:0] en, input int p);
    @(negedge clk);
    rx_n = 0;
    arm = 1'b1; grp_en = en; post_len = 8'(p);
    @(negedge clk);
    arm = 1'b0;
    check(busy == 1'b1, "R7 busy after arm", int'(busy), 1);
  endtask

  // external-strobe capture with bench-computed expected readback
  task automatic run_capture(input logic [3:0] en, input int t, input int p,
                             input bit coinc, input bit extra_arm);
    int ng, spw, cap, need, n, first, nexp, total, bad, bad_i;
    ext_sel = 1'b1; div_n = 8'd200;
    ng = popc(en); spw = 4 / ng; cap = WORDS * spw;
    need = t + p;
    n = ((need + spw - 1) / spw) * spw;
    total = ((n > t + 1) ? n : t + 1) + 4;
    do_arm(en, p);
    for (int k = 0; k < total; k++) begin
      if (!coinc && k == t) begin
        @(negedge clk); ext_strobe = 1'b0; trigger = 1'b1; arm = 1'b0;
      end
      @(negedge clk);
      smp[k] = $urandom;
      sample_in = smp[k];
      ext_strobe = 1'b1;
      trigger = coinc && (k == t);
      arm = extra_arm && (k == 2);
      if (extra_arm && k == 2) grp_en = ~en;
      for (int g = 0; g < int'($urandom % 3); g++) begin
        @(negedge clk); ext_strobe = 1'b0; trigger = 1'b0; arm = 1'b0;
      end
    end
    @(negedge clk); ext_strobe = 1'b0; trigger = 1'b0; arm = 1'b0;
    wait_idle();
    @(negedge clk);
    first = (n > cap) ? n - cap : 0;
    nexp = (n - first) * ng;
    check(rx_n == nexp, (n > cap) ? "R4 R6 byte count (wrapped)" : "R10 R6 byte count",
          rx_n, nexp);
    bad = 0; bad_i = 0;
    begin
      int j;
      j = 0;
      for (int s = first; s < n; s++)
        for (int g = 0; g < 4; g++)
          if (en[g]) begin
            if (j < rx_n && j < 512 && !bad && rx[j] != smp[s][g*8 +: 8]) begin
              bad = 1; bad_i = j;
              check(0, "R2 R3 R5 readback byte", int'(rx[j]), int'(smp[s][g*8 +: 8]));
            end
            j++;
          end
    end
    if (!bad) check(1, "R2 R3 R5 readback content", 0, 0);
    if (nexp > 0)
      check(fall_cyc == last_hs + 1, "R7 busy falls after last byte", fall_cyc, last_hs + 1);
    check(out_valid == 1'b0, "R7 no valid when idle", int'(out_valid), 0);
    if (bad_i < 0) $display("unreachable");
  endtask

  // internal divider capture on a ramp input
  task automatic run_divider(input int nd);
    int words, bad;
    logic [31:0] a, b;
    ext_sel = 1'b0; div_n = 8'(nd);
    do_arm(4'hF, 5);
    for (int i = 0; i < 4000 && busy; i++) begin
      @(negedge clk);
      sample_in = sample_in + 1;
      ext_strobe = $urandom % 2;
      trigger = (i == 60);
    end
    @(negedge clk); trigger = 1'b0; ext_strobe = 1'b0;
    words = rx_n / 4;
    check(words >= 2 && (rx_n % 4) == 0, "R1 divider capture length", rx_n, 8);
    bad = 0;
    for (int w = 1; w < words && w < 128; w++) begin
      a = {rx[4*w-1], rx[4*w-2], rx[4*w-3], rx[4*w-4]};
      b = {rx[4*w+3], rx[4*w+2], rx[4*w+1], rx[4*w]};
      if (!bad && (b - a) != 32'(nd + 1)) begin
        bad = 1;
        check(0, "R1 divider spacing", int'(b - a), nd + 1);
      end
    end
    if (!bad) check(1, "R1 divider spacing", 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R11 state during reset",
          int'({busy, out_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R11 state after reset",
          int'({busy, out_valid}), 0);

    // R8: arm with no groups
    arm = 1'b1; grp_en = 4'h0;
    @(negedge clk); arm = 1'b0;
    check(busy == 1'b0, "R8 arm with no groups", int'(busy), 0);

    // R4: depth per group count, long pre-trigger run wraps
    run_capture(4'h1, 150, 3, 1'b0, 1'b0);
    run_capture(4'h6, 150, 3, 1'b1, 1'b0);
    run_capture(4'hB, 150, 3, 1'b0, 1'b0);
    run_capture(4'hF, 150, 3, 1'b1, 1'b0);
    // R10 short captures, R6 word-boundary endings
    run_capture(4'h1, 5, 2, 1'b0, 1'b0);
    run_capture(4'h4, 0, 0, 1'b0, 1'b0);
    run_capture(4'h4, 3, 0, 1'b1, 1'b0);
    run_capture(4'h5, 7, 4, 1'b1, 1'b0);
    // R8 arm during capture ignored
    run_capture(4'h3, 20, 9, 1'b0, 1'b1);
    // R1 internal divider
    run_divider(2);
    run_divider(0);
    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      logic [3:0] en;
      en = 4'($urandom % 15) + 4'd1;
      run_capture(en, int'($urandom % 90), int'($urandom % 40),
                  bit'($urandom % 2), ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", pcyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule